// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is the host-facing control port of an audio decoder. It answers on a two-wire I2C bus at up to 400 kHz as a 7-bit slave. It holds five 8-bit control registers that the host writes, and it streams three status bytes that the rest of the chip supplies when the host reads. SCL and SDA are oversampled by a system clock of 8 MHz or faster. SDA is driven open-drain, so the block only ever pulls the line low. Clock stretching and 10-bit addressing are not provided.

A write names a register index after the address byte. Data bytes then fill consecutive registers, and the index returns to the first register after the last. A read always begins at the status byte and runs through the three read bytes in a loop. Two strap pins set the power-on contents of register 0, which carries the mute, overload and filter-gain controls. An address-select pin sets the lowest address bit, so two of these blocks can share one bus.

Top module: `ctlI2cSlave`

## Requirements
- R1: The slave acknowledges an address byte, by pulling SDA low during the 9th SCL clock, only when the byte's upper seven bits equal 1,0,1,1,0,1 followed by the level of `addrSel`. With `addrSel` low the write and read bytes are B4h and B5h; with it high they are B6h and B7h. Every other address byte gets no acknowledge.
- R2: The all-zero general call byte 00h is never acknowledged.
- R3: In a write, the byte after the address is a register index. Each data byte that follows is acknowledged and stored in the register at the current index. Register k appears on `regOut[8k+7:8k]`.
- R4: After each stored data byte the index advances by one. After a byte is stored at index 4, the index returns to 0.
- R5: An index byte above 04h is not acknowledged. Every data byte after it, up to the next STOP or START, is also not acknowledged and leaves all registers unchanged.
- R6: In a read, the slave sends `statusIn`, then `errCountIn`, then `extraIn`, then `statusIn` again, and so on, each byte MSB first. Every read transaction starts with `statusIn`.
- R7: After the master leaves a read byte unacknowledged, the slave drives SDA low at no time until the next START.
- R8: A START or STOP that arrives part way through a byte abandons that byte, and no register is written from it. A START puts the slave back into the address phase.
- R9: While `rstN` is low, register 0 loads bit 0 = `muteStrapN` (1 = sound on, 0 = muted), bit 1 = bit 2 = NOT `gainStrapN` (overload flag and 12 dB gain select), and 0 in all other bits. Registers 1 to 4 load 00h.
- R10: SCL and SDA pass through two flip-flops. The acknowledge pull-down appears on the third rising `clk` edge after the SCL pin falls at the end of the 8th bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 MHz |
| rstN | input | 1 | Synchronous reset, active low; straps are sampled while it is low |
| scl | input | 1 | Bus clock as seen at the pin |
| sdaIn | input | 1 | Bus data as seen at the pin |
| sdaDriveLow | output | 1 | 1 = pull SDA low (open-drain enable) |
| addrSel | input | 1 | Sets the least significant address bit |
| muteStrapN | input | 1 | Power-on mute strap, low = start muted |
| gainStrapN | input | 1 | Power-on gain strap, low = 12 dB gain and overload flag set |
| statusIn | input | 8 | First read byte |
| errCountIn | input | 8 | Second read byte |
| extraIn | input | 8 | Third read byte |
| regOut | output | 40 | Five control registers, register k at bits 8k+7:8k |

## Verification
Every bus-side result passes through the two synchroniser stages and one state register. An acknowledge or a new read bit therefore appears three `clk` rising edges after the SCL pin edge that starts it. The bench moves SCL only every eight clocks and samples SDA at the middle of the SCL-high phase, well after that window. R10 is checked exactly: the bench counts falling clock edges from the SCL fall and expects the pull-down on the third, not the second. Register contents are read from `regOut` only after STOP, once all writes are complete.

// File: rtl/ctlI2cPkg.sv
package ctlI2cPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_WDATA,
    ST_RDATA
  } busState_t;

  typedef struct packed {
    logic captureBit;
    logic latchSub;
    logic writeReg;
    logic clearRd;
    logic loadTx;
    logic shiftTx;
    logic txRelease;
  } dpStrobe_t;

endpackage

// File: rtl/ctlI2cCtrl.sv
module ctlI2cCtrl
  import ctlI2cPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      scl,
  input  logic      sdaIn,
  input  logic      addrMatch,
  input  logic      rxLsb,
  input  logic      subInRange,
  output dpStrobe_t strobe,
  output logic      sampledBit,
  output logic      ackDrive
);

  logic [2:0] sclSync;
  logic [2:0] sdaSync;
  logic sclRise, sclFall, sclHigh, startDet, stopDet;

  busState_t state, stateNxt;
  logic [3:0] bitCnt, cntNxt;
  logic ackNxt, rwReg, rwNxt, masterNack, nackNxt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= 3'b111;
      sdaSync <= 3'b111;
    end else begin
      sclSync <= {sclSync[1:0], scl};
      sdaSync <= {sdaSync[1:0], sdaIn};
    end
  end

  assign sclRise    = sclSync[1] & ~sclSync[2];
  assign sclFall    = ~sclSync[1] & sclSync[2];
  assign sclHigh    = sclSync[1] & sclSync[2];
  assign startDet   = sclHigh & sdaSync[2] & ~sdaSync[1];
  assign stopDet    = sclHigh & ~sdaSync[2] & sdaSync[1];
  assign sampledBit = sdaSync[1];

  always_comb begin
    stateNxt = state;
    cntNxt   = bitCnt;
    ackNxt   = ackDrive;
    rwNxt    = rwReg;
    nackNxt  = masterNack;
    strobe   = '0;
    if (startDet) begin
      stateNxt         = ST_ADDR;
      cntNxt           = 4'd0;
      ackNxt           = 1'b0;
      strobe.txRelease = 1'b1;
    end else if (stopDet) begin
      stateNxt         = ST_IDLE;
      cntNxt           = 4'd0;
      ackNxt           = 1'b0;
      strobe.txRelease = 1'b1;
    end else if (state != ST_IDLE) begin
      if (sclRise) begin
        if (bitCnt < 4'd8) begin
          cntNxt = bitCnt + 4'd1;
          if (state != ST_RDATA) strobe.captureBit = 1'b1;
        end else if (bitCnt == 4'd8) begin
          cntNxt = 4'd9;
          if (state == ST_RDATA) nackNxt = sampledBit;
        end
      end else if (sclFall) begin
        if (bitCnt == 4'd8) begin
          case (state)
            ST_ADDR: begin
              if (addrMatch) begin
                ackNxt         = 1'b1;
                rwNxt          = rxLsb;
                strobe.clearRd = 1'b1;
              end else begin
                stateNxt = ST_IDLE;
              end
            end
            ST_SUB: begin
              if (subInRange) begin
                ackNxt          = 1'b1;
                strobe.latchSub = 1'b1;
              end
            end
            ST_WDATA: begin
              ackNxt          = 1'b1;
              strobe.writeReg = 1'b1;
            end
            ST_RDATA: strobe.txRelease = 1'b1;
            default: ;
          endcase
        end else if (bitCnt == 4'd9) begin
          ackNxt = 1'b0;
          cntNxt = 4'd0;
          case (state)
            ST_ADDR: begin
              if (rwReg) begin
                stateNxt      = ST_RDATA;
                strobe.loadTx = 1'b1;
              end else begin
                stateNxt = ST_SUB;
              end
            end
            ST_SUB:   stateNxt = ackDrive ? ST_WDATA : ST_IDLE;
            ST_RDATA: begin
              if (masterNack) stateNxt = ST_IDLE;
              else strobe.loadTx = 1'b1;
            end
            default: ;
          endcase
        end else if (state == ST_RDATA && bitCnt != 4'd0) begin
          strobe.shiftTx = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= 4'd0;
      ackDrive   <= 1'b0;
      rwReg      <= 1'b0;
      masterNack <= 1'b0;
    end else begin
      state      <= stateNxt;
      bitCnt     <= cntNxt;
      ackDrive   <= ackNxt;
      rwReg      <= rwNxt;
      masterNack <= nackNxt;
    end
  end

  assert_ack_needs_match_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && ackDrive) |-> addrMatch);

  assert_ack_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    ackDrive |-> (bitCnt >= 4'd8));

  assert_start_to_addr_R8: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_ADDR && bitCnt == 4'd0 && !ackDrive));

  assert_stop_to_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stopDet && !startDet) |=> (state == ST_IDLE && !ackDrive));

endmodule

// File: rtl/ctlI2cData.sv
module ctlI2cData
  import ctlI2cPkg::*;
#(
  parameter int          NUM_REGS  = 5,
  parameter logic [5:0]  ADDR_BASE = 6'b101101
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strobe,
  input  logic                  sampledBit,
  input  logic                  addrSel,
  input  logic                  muteStrapN,
  input  logic                  gainStrapN,
  input  logic [7:0]            statusIn,
  input  logic [7:0]            errCountIn,
  input  logic [7:0]            extraIn,
  output logic                  addrMatch,
  output logic                  rxLsb,
  output logic                  subInRange,
  output logic                  txDriveLow,
  output logic [NUM_REGS*8-1:0] regOut
);

  localparam int SUB_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(NUM_REGS - 1);

  logic [7:0]       rxShift;
  logic [SUB_W-1:0] subAddr;
  logic [1:0]       readIdx;
  logic [7:0]       rdByte;
  logic [7:0]       txShift;

  always_ff @(posedge clk) begin
    if (!rstN) rxShift <= 8'h00;
    else if (strobe.captureBit) rxShift <= {rxShift[6:0], sampledBit};
  end

  assign addrMatch  = (rxShift[7:1] == {ADDR_BASE, addrSel});
  assign rxLsb      = rxShift[0];
  assign subInRange = (rxShift < 8'(NUM_REGS));

  always_ff @(posedge clk) begin
    if (!rstN) subAddr <= '0;
    else if (strobe.latchSub) subAddr <= rxShift[SUB_W-1:0];
    else if (strobe.writeReg) subAddr <= (subAddr == SUB_LAST) ? '0 : subAddr + 1'b1;
  end

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    logic [7:0] rstVal;
    logic [7:0] regQ;
    if (gi == 0) begin : g_strap
      assign rstVal = {5'b00000, ~gainStrapN, ~gainStrapN, muteStrapN};
    end else begin : g_zero
      assign rstVal = 8'h00;
    end
    always_ff @(posedge clk) begin
      if (!rstN) regQ <= rstVal;
      else if (strobe.writeReg && subAddr == SUB_W'(gi)) regQ <= rxShift;
    end
    assign regOut[gi*8 +: 8] = regQ;
  end

  always_comb begin
    case (readIdx)
      2'd0:    rdByte = statusIn;
      2'd1:    rdByte = errCountIn;
      default: rdByte = extraIn;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readIdx    <= 2'd0;
      txShift    <= 8'h00;
      txDriveLow <= 1'b0;
    end else begin
      if (strobe.clearRd) readIdx <= 2'd0;
      if (strobe.loadTx) begin
        txShift    <= {rdByte[6:0], 1'b0};
        txDriveLow <= ~rdByte[7];
        readIdx    <= (readIdx == 2'd2) ? 2'd0 : readIdx + 2'd1;
      end else if (strobe.shiftTx) begin
        txShift    <= {txShift[6:0], 1'b0};
        txDriveLow <= ~txShift[7];
      end else if (strobe.txRelease) begin
        txDriveLow <= 1'b0;
      end
    end
  end

  assert_sub_in_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    subAddr <= SUB_LAST);

  assert_index_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.writeReg && subAddr == SUB_LAST) |=> (subAddr == '0));

  assert_tx_strobes_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadTx, strobe.shiftTx, strobe.txRelease}));

  assert_read_restart_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearRd |=> (readIdx == 2'd0));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.txRelease && !strobe.loadTx) |=> !txDriveLow);

endmodule

// File: rtl/ctlI2cSlave.sv
module ctlI2cSlave
  import ctlI2cPkg::*;
#(
  parameter int         NUM_REGS  = 5,
  parameter logic [5:0] ADDR_BASE = 6'b101101
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  scl,
  input  logic                  sdaIn,
  output logic                  sdaDriveLow,
  input  logic                  addrSel,
  input  logic                  muteStrapN,
  input  logic                  gainStrapN,
  input  logic [7:0]            statusIn,
  input  logic [7:0]            errCountIn,
  input  logic [7:0]            extraIn,
  output logic [NUM_REGS*8-1:0] regOut
);

  dpStrobe_t strobe;
  logic sampledBit, ackDrive, addrMatch, rxLsb, subInRange, txDriveLow;

  ctlI2cCtrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .scl        (scl),
    .sdaIn      (sdaIn),
    .addrMatch  (addrMatch),
    .rxLsb      (rxLsb),
    .subInRange (subInRange),
    .strobe     (strobe),
    .sampledBit (sampledBit),
    .ackDrive   (ackDrive)
  );

  ctlI2cData #(
    .NUM_REGS  (NUM_REGS),
    .ADDR_BASE (ADDR_BASE)
  ) data_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .sampledBit (sampledBit),
    .addrSel    (addrSel),
    .muteStrapN (muteStrapN),
    .gainStrapN (gainStrapN),
    .statusIn   (statusIn),
    .errCountIn (errCountIn),
    .extraIn    (extraIn),
    .addrMatch  (addrMatch),
    .rxLsb      (rxLsb),
    .subInRange (subInRange),
    .txDriveLow (txDriveLow),
    .regOut     (regOut)
  );

  assign sdaDriveLow = ackDrive | txDriveLow;

  assert_single_driver_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(ackDrive && txDriveLow));

endmodule

// File: tb/ctlI2cSlave_tb.sv
module ctlI2cSlave_tb_top;

  localparam int H = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic addrSel = 1'b0;
  logic muteStrapN = 1'b1;
  logic gainStrapN = 1'b1;
  logic [7:0] statusIn = 8'h00;
  logic [7:0] errCountIn = 8'h00;
  logic [7:0] extraIn = 8'h00;
  logic sdaDriveLow;
  logic sdaLine;
  logic [39:0] regOut;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] model [5];

  always #4 clk = ~clk;

  assign sdaLine = sdaM & ~sdaDriveLow;

  ctlI2cSlave dut_i (
    .clk(clk), .rstN(rstN), .scl(sclM), .sdaIn(sdaLine), .sdaDriveLow(sdaDriveLow),
    .addrSel(addrSel), .muteStrapN(muteStrapN), .gainStrapN(gainStrapN),
    .statusIn(statusIn), .errCountIn(errCountIn), .extraIn(extraIn), .regOut(regOut)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2cStart();
    sdaM = 1'b1; hc(H/2); sclM = 1'b1; hc(H); sdaM = 1'b0; hc(H); sclM = 1'b0; hc(H/2);
  endtask

  task automatic i2cStop();
    sdaM = 1'b0; hc(H/2); sclM = 1'b1; hc(H); sdaM = 1'b1; hc(H);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; hc(H/2); sclM = 1'b1; hc(H); sclM = 1'b0; hc(H/2);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1; hc(H/2); sclM = 1'b1; hc(H/2);
    ack = ~sdaLine;
    hc(H/2); sclM = 1'b0; hc(H/2);
  endtask

  task automatic readByte(output logic [7:0] b, input logic mAck);
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      sdaM = 1'b1; hc(H/2); sclM = 1'b1; hc(H/2);
      b = {b[6:0], sdaLine};
      hc(H/2); sclM = 1'b0; hc(H/2);
    end
    sdaM = ~mAck; hc(H/2); sclM = 1'b1; hc(H); sclM = 1'b0; hc(H/2);
    sdaM = 1'b1;
  endtask

  task automatic checkRegs(input string req);
    for (int k = 0; k < 5; k++)
      chk(regOut[k*8 +: 8] == model[k], req, int'(regOut[k*8 +: 8]), int'(model[k]));
  endtask

  task automatic doReset(input logic gN, input logic mN);
    gainStrapN = gN; muteStrapN = mN;
    rstN = 1'b0; hc(4); rstN = 1'b1; hc(4);
  endtask

  initial begin
    logic ack;
    logic [7:0] rb;
    logic [7:0] exp0;
    logic [7:0] addrW;
    logic [7:0] addrR;
    logic [7:0] rdSeq [3];
    int cnt;
    int idx;
    bit expAck;

    // R9: every strap combination
    for (int s = 0; s < 4; s++) begin
      doReset(s[1], s[0]);
      exp0 = {5'b0, ~s[1], ~s[1], s[0]};
      chk(regOut == {32'h0, exp0}, "R9 reset contents", int'(regOut[7:0]), int'(exp0));
      chk(sdaDriveLow == 1'b0, "R9 idle SDA after reset", int'(sdaDriveLow), 0);
    end
    doReset(1'b1, 1'b1);
    model[0] = 8'h01;
    for (int k = 1; k < 5; k++) model[k] = 8'h00;

    // R1/R2: every address byte with both select levels
    for (int sel = 0; sel < 2; sel++) begin
      addrSel = sel[0];
      for (int b = 0; b < 256; b++) begin
        expAck = (b[7:1] == {6'b101101, sel[0]});
        i2cStart();
        sendByte(8'(b), ack);
        if (b == 0) chk(ack == 1'b0, "R2 general call", int'(ack), 0);
        else chk(ack == expAck, "R1 address match", int'(ack), int'(expAck));
        if (ack && b[0]) readByte(rb, 1'b0);
        i2cStop();
      end
    end
    checkRegs("R1 no register change from address sweep");

    addrSel = 1'b1;
    addrW = 8'hB6;
    addrR = 8'hB7;

    // R10: acknowledge latency counted in clock edges
    i2cStart();
    for (int i = 7; i >= 1; i--) sendBit(addrW[i]);
    sdaM = addrW[0]; hc(H/2); sclM = 1'b1; hc(H); sclM = 1'b0;
    cnt = 0;
    for (int k = 1; k <= 6; k++) begin
      hc(1);
      if (sdaDriveLow && cnt == 0) cnt = k;
    end
    chk(cnt == 3, "R10 ack latency", cnt, 3);
    sdaM = 1'b1; hc(2); sclM = 1'b1; hc(H); sclM = 1'b0; hc(H/2);
    i2cStop();

    // R3/R4/R5: index sweep with bursts that wrap
    for (int sub = 0; sub < 8; sub++) begin
      expAck = (sub < 5);
      i2cStart();
      sendByte(addrW, ack);
      chk(ack == 1'b1, "R3 address ack", int'(ack), 1);
      sendByte(8'(sub), ack);
      chk(ack == expAck, "R5 index ack", int'(ack), int'(expAck));
      idx = sub;
      for (int n = 0; n < sub + 2; n++) begin
        rb = 8'(8'h40 + sub * 16 + n);
        sendByte(rb, ack);
        chk(ack == expAck, expAck ? "R3 data ack" : "R5 data ignored", int'(ack), int'(expAck));
        if (expAck) begin
          model[idx] = rb;
          idx = (idx + 1) % 5;
        end
      end
      i2cStop();
      checkRegs(expAck ? "R4 register contents" : "R5 registers unchanged");
    end

    // R6/R7: read order and release after master NACK
    statusIn = 8'hA5; errCountIn = 8'h3C; extraIn = 8'h81;
    rdSeq[0] = 8'hA5; rdSeq[1] = 8'h3C; rdSeq[2] = 8'h81;
    i2cStart();
    sendByte(addrR, ack);
    chk(ack == 1'b1, "R6 read address ack", int'(ack), 1);
    for (int n = 0; n < 7; n++) begin
      readByte(rb, n != 6);
      chk(rb == rdSeq[n % 3], "R6 read sequence", int'(rb), int'(rdSeq[n % 3]));
    end
    cnt = 0;
    for (int n = 0; n < 9 * 2 * H; n++) begin
      if (n % (2 * H) == 0) sclM = ~sclM;
      if (n % (2 * H) == H) sclM = ~sclM;
      hc(1);
      if (sdaDriveLow) cnt++;
    end
    sclM = 1'b0; hc(H/2);
    chk(cnt == 0, "R7 released after NACK", cnt, 0);
    i2cStop();
    statusIn = 8'h5A;
    i2cStart();
    sendByte(addrR, ack);
    readByte(rb, 1'b0);
    chk(rb == 8'h5A, "R6 read restarts at status", int'(rb), 8'h5A);
    i2cStop();

    // R8: repeated START mid-byte
    i2cStart();
    sendByte(addrW, ack);
    sendByte(8'h01, ack);
    for (int i = 7; i >= 4; i--) sendBit(rb[i] ^ 1'b1);
    i2cStart();
    sendByte(addrW, ack);
    chk(ack == 1'b1, "R8 address after repeated START", int'(ack), 1);
    sendByte(8'h02, ack);
    sendByte(8'hC3, ack);
    model[2] = 8'hC3;
    i2cStop();
    checkRegs("R8 repeated START abort");

    // R8: STOP mid-byte
    i2cStart();
    sendByte(addrW, ack);
    sendByte(8'h00, ack);
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b0);
    i2cStop();
    checkRegs("R8 STOP abort");
    i2cStart();
    sendByte(addrW, ack);
    sendByte(8'h04, ack);
    sendByte(8'h77, ack);
    sendByte(8'h99, ack);
    model[4] = 8'h77; model[0] = 8'h99;
    i2cStop();
    checkRegs("R4 wrap after abort");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule